// File: doc/BRIEF.md
# PHY Management Access Register Bridge

This block turns one 32-bit software register into a single clause-22 management transaction on the MDC/MDIO pins. Software writes the register with the request bit set, along with the direction, a 5-bit PHY address, a 5-bit PHY register address and, for writes, 16 bits of data. The bridge then shifts out the full management frame on MDIO while it generates MDC from the system clock. For a read, it releases MDIO at the turnaround and samples the PHY's 16 data bits.

The request bit serves both as the start trigger and as the busy flag. It stays set for the whole frame and clears by itself when the frame ends. Software polls the register until that bit reads 0. After a read, the data field then holds the word the PHY returned. Writes to the register while a frame is in progress have no effect. MDC runs only while a transaction is active.

Top module: `mdio_access_bridge`

## Requirements
- R1: After reset the register reads 0x00000000, MDC is low and the MDIO output enable is low.
- R2: A register write with bit 31 set, accepted while bit 31 is clear, starts a transaction. Bit 31 reads 1 from the next cycle until the frame is over and then clears by itself. Bit 30 (1 = write, 0 = read), bits 25:21 (PHY address) and bits 20:16 (PHY register) read back as written.
- R3: A write frame has 64 MDC periods. In MSB-first order, bit by bit on the rising edge of MDC, it carries 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10 and the 16 data bits of register bits 15:0. MDIO is driven for all 64 bits.
- R4: A read frame drives 32 ones, start 01, opcode 10, PHY address and register address (46 bits). It then releases MDIO (output enable low) for the 2 turnaround bits and the 16 data bits.
- R5: During a read, MDIO is sampled on each of the last 16 MDC rising edges, most significant bit first. Once bit 31 has cleared, the sampled word appears in bits 15:0.
- R6: A register write that arrives while bit 31 is set is ignored. The fields keep their values, no further frame starts, and the running frame completes unchanged.
- R7: A register write with bit 31 clear, while idle, updates bits 30 and 25:0 without starting a frame. No MDC edge appears.
- R8: MDC has a period of 2*CLK_DIV clock cycles and starts low. Whenever bit 31 is clear, MDC is low and MDIO is released.
- R9: Bits 29:26 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = bridge drives the line) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench acts as a PHY model. It records MDIO and its output enable on every MDC rising edge and answers reads on MDC falling edges, so frames are checked bit by bit.

The corner cases are these:
- Turnaround handover: a bridge that keeps driving into the turnaround would fight the PHY, and one that samples one edge early or late would return a shifted word.
- Writes during a busy frame: a bridge that accepts them would corrupt the fields or launch a second frame.
- Field writes with the request bit clear: one that starts a frame on such a write would toggle MDC.
- The final MDC edge: a bridge with an off-by-one bit counter would produce 63 or 65 periods and clear the busy bit at the wrong time.

// File: rtl/mab_pkg.sv
package mab_pkg;

    localparam int FRAME_BITS = 64;  // full clause-22 frame with preamble
    localparam int PRE_BITS   = 32;  // preamble ones
    localparam int HDR_BITS   = 46;  // bits driven before turnaround on a read
    localparam int DATA_FIRST = 48;  // index of first data bit in the frame

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic        go;     // request / busy
        logic        wr;     // 1 = write, 0 = read
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t word_to_cmd(logic [31:0] w);
        mgmt_cmd_t c;
        c.go    = w[31];
        c.wr    = w[30];
        c.phy   = w[25:21];
        c.regad = w[20:16];
        c.data  = w[15:0];
        return c;
    endfunction

    function automatic logic [31:0] cmd_to_word(mgmt_cmd_t c);
        return {c.go, c.wr, 4'b0000, c.phy, c.regad, c.data};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c);
        mdio_op_e   op;
        logic [1:0] ta;
        op = c.wr ? OP_WRITE : OP_READ;
        ta = c.wr ? 2'b10 : 2'b11;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta, c.data};
    endfunction

endpackage

// File: rtl/mab_mdc_gen.sv
module mab_mdc_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick    = (cnt == CW'(CLK_DIV - 1));
    assign rise_ev = run && tick && !mdc;
    assign fall_ev = run && tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: with the bridge idle, the management clock is parked low
    assert_mdc_parked_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mab_frame_shifter.sv
module mab_frame_shifter
    import mab_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  is_write,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  rise_ev,
    input  logic                  fall_ev,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rd_data
);
    localparam int IW = $clog2(FRAME_BITS);

    logic                  active;
    logic                  wr_q;
    logic [IW-1:0]         bit_idx;
    logic [FRAME_BITS-1:0] sreg;
    logic                  last_bit;
    logic                  in_data;

    assign last_bit = (bit_idx == IW'(FRAME_BITS - 1));
    assign in_data  = (bit_idx >= IW'(DATA_FIRST));
    assign mdio_o   = sreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            wr_q    <= 1'b0;
            bit_idx <= '0;
            sreg    <= '0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                wr_q    <= is_write;
                bit_idx <= '0;
                sreg    <= frame;
                mdio_oe <= 1'b1;
            end else if (active) begin
                if (rise_ev && !wr_q && in_data)
                    rd_data <= {rd_data[14:0], mdio_i};
                if (fall_ev) begin
                    if (last_bit) begin
                        active  <= 1'b0;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
                        mdio_oe <= wr_q || ((bit_idx + 1'b1) < IW'(HDR_BITS));
                    end
                end
            end
        end
    end

    // R4: from the turnaround on, a read leaves the line to the PHY
    assert_release_read_R4: assert property (@(posedge clk) disable iff (rst)
        (active && !wr_q && bit_idx >= IW'(HDR_BITS)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_access_bridge.sv
module mdio_access_bridge
    import mab_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_cmd_t cmd_q;
    mgmt_cmd_t wr_cmd;
    logic      accept;
    logic      start;
    logic      rise_ev;
    logic      fall_ev;
    logic      frame_done;
    logic [15:0] rd_data;

    assign wr_cmd    = word_to_cmd(reg_wdata);
    assign accept    = reg_wr && !cmd_q.go;
    assign start     = accept && wr_cmd.go;
    assign reg_rdata = cmd_to_word(cmd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= wr_cmd;
        end else if (frame_done) begin
            cmd_q.go <= 1'b0;
            if (!cmd_q.wr)
                cmd_q.data <= rd_data;
        end
    end

    mab_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk     (clk),
        .rst     (rst),
        .run     (cmd_q.go),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mab_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_write (wr_cmd.wr),
        .frame    (build_frame(wr_cmd)),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (frame_done),
        .rd_data  (rd_data)
    );

    // R8: idle means clock low and line released
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.go |-> (!mdc && !mdio_oe));

    // R6: command fields cannot move while a frame runs
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_q.go |=> $stable(reg_rdata[30:16]));

    // R2: the busy bit only clears after the shifter reports the end of frame
    assert_done_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_q.go) |-> $past(frame_done));

endmodule

// File: tb/tb_mdio_access_bridge.sv
module tb_mdio_access_bridge;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rise_n = 0, r0 = 0, r1 = 0;
    logic [63:0] cap_v, cap_oe;
    logic [15:0] resp = '0;

    always #10 clk = ~clk;

    mdio_access_bridge #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(negedge clk) cyc <= cyc + 1;

    // PHY model: capture line on each MDC rise, answer reads on MDC fall
    always @(posedge mdc) begin
        if (rise_n < 64) begin
            cap_v[63-rise_n]  = mdio_o;
            cap_oe[63-rise_n] = mdio_oe;
        end
        if (rise_n == 0) r0 = cyc;
        if (rise_n == 1) r1 = cyc;
        rise_n = rise_n + 1;
    end

    always @(negedge mdc) begin
        if (rise_n >= 48 && rise_n < 64) mdio_i = resp[63-rise_n];
        else mdio_i = 1'b1;
    end

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!reg_rdata[31]) break;
        end
    endtask

    function automatic logic [31:0] mk(logic go, logic wr, logic [4:0] p,
                                       logic [4:0] r, logic [15:0] d);
        return {go, wr, 4'b0000, p, r, d};
    endfunction

    task automatic t_reset();
        chk("R1 rdata", 64'(reg_rdata), 64'h0);
        chk("R1 mdc", 64'(mdc), 64'h0);
        chk("R1 oe", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_write(logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
        rise_n = 0;
        bus_write(mk(1'b1, 1'b1, p, r, d));
        chk("R2 busy set", 64'(reg_rdata[31]), 64'h1);
        wait_idle();
        chk("R3 mdc periods", 64'(rise_n), 64'd64);
        chk("R3 frame bits", cap_v, exp);
        chk("R3 driven", cap_oe, {64{1'b1}});
        chk("R2 readback", 64'(reg_rdata), 64'(mk(1'b0, 1'b1, p, r, d)));
        chk("R8 idle mdc/oe", 64'({mdc, mdio_oe}), 64'h0);
    endtask

    task automatic t_read(logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
        resp = d;
        rise_n = 0;
        bus_write(mk(1'b1, 1'b0, p, r, 16'h0));
        wait_idle();
        chk("R4 header bits", 64'(cap_v[63:18]), 64'(exp[63:18]));
        chk("R4 header driven", 64'(cap_oe[63:18]), 64'h3FFF_FFFF_FFFF);
        chk("R4 released", 64'(cap_oe[17:0]), 64'h0);
        chk("R5 read data", 64'(reg_rdata), 64'(mk(1'b0, 1'b0, p, r, d)));
        chk("R8 mdc period", 64'(r1 - r0), 64'(2 * DIV));
    endtask

    task automatic t_busy();
        resp = 16'hA5A5;
        rise_n = 0;
        bus_write(mk(1'b1, 1'b0, 5'd6, 5'd1, 16'h0));
        repeat (100) @(negedge clk);
        bus_write(mk(1'b1, 1'b1, 5'd3, 5'd9, 16'h1234));
        chk("R6 still busy", 64'(reg_rdata[31]), 64'h1);
        chk("R6 fields kept", 64'(reg_rdata[30:16]), 64'(mk(1'b0, 1'b0, 5'd6, 5'd1, 16'h0) >> 16));
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R6 no second frame", 64'(rise_n), 64'd64);
        chk("R6 result", 64'(reg_rdata), 64'(mk(1'b0, 1'b0, 5'd6, 5'd1, 16'hA5A5)));
    endtask

    task automatic t_fields();
        logic [31:0] w;
        w = mk(1'b0, 1'b1, 5'h11, 5'h07, 16'hBEEF) | 32'h3C00_0000;
        rise_n = 0;
        bus_write(w);
        repeat (40) @(negedge clk);
        chk("R7 no mdc", 64'(rise_n), 64'd0);
        chk("R7 fields", 64'(reg_rdata), 64'(w & 32'hC3FF_FFFF));
        chk("R9 bits 29:26", 64'(reg_rdata[29:26]), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(5'd6, 5'd0, 16'h9000);
        t_read(5'd6, 5'd17, 16'h0002);
        t_busy();
        t_fields();
        t_read(5'h1F, 5'h1F, 16'h8001);
        t_write(5'd0, 5'd0, 16'hFFFF);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule